// File: doc/BRIEF.md
# PTP Event Snapshot Qualifier

This block sits beside a network MAC's receive and transmit paths. It decides, for each precision-time-protocol frame seen on either path, whether the timestamp unit should latch a snapshot of the system time. An upstream parser gives a one-cycle frame strobe together with the 4-bit message-type nibble taken from the PTP header. The qualifier combines that nibble with three configuration inputs: a 2-bit clock-mode select, a master/slave role bit and an event-only bit. It returns a registered one-cycle snapshot decision.

A global timestamp enable gates all of this. While it is low, no frame produces a snapshot, whatever its type. The configuration inputs are sampled in the same cycle as the frame strobe. Software may therefore change the mode between frames, and each frame is judged only by the settings present alongside it.

Top module: `snap_filter_top`

## Requirements
- R1: While rstN is low, and in the first cycle after reset is released, snapTake is 0.
- R2: With modeSel 2'b00 or 2'b01 and eventOnly 0, a snapshot is taken for Sync (4'h0), Follow_Up (4'h8), Delay_Req (4'h1) and Delay_Resp (4'h9), whatever the value of masterSel.
- R3: With modeSel 2'b00 or 2'b01, eventOnly 1 and masterSel 1, only Delay_Req (4'h1) is snapshotted.
- R4: With modeSel 2'b00 or 2'b01, eventOnly 1 and masterSel 0, only Sync (4'h0) is snapshotted.
- R5: With modeSel 2'b10, masterSel has no effect. With eventOnly 0, Sync, Follow_Up, Delay_Req and Delay_Resp are snapshotted. With eventOnly 1, only Sync and Follow_Up are snapshotted.
- R6: With modeSel 2'b11 and eventOnly 0, Sync, Follow_Up, Delay_Req, Delay_Resp, Pdelay_Req (4'h2) and Pdelay_Resp (4'h3) are snapshotted.
- R7: With modeSel 2'b11 and eventOnly 1, only Sync, Pdelay_Req and Pdelay_Resp are snapshotted.
- R8: While tsEnable is low in the strobe cycle, the frame never produces a snapshot.
- R9: The message-type values 4'h4 to 4'h7 and 4'hA to 4'hF never produce a snapshot in any mode.
- R10: snapTake rises in the cycle after the clock edge that samples frameValid high, and stays high for that one cycle only. A cycle with frameValid low is followed by snapTake low.
- R11: The mode and enable inputs count only in the strobe cycle. A change on them in the cycle after a strobe does not alter that frame's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tsEnable | input | 1 | Global timestamp enable |
| frameValid | input | 1 | One-cycle strobe marking a PTP frame |
| msgType | input | 4 | Message-type nibble of that frame |
| modeSel | input | 2 | Clock-mode select |
| masterSel | input | 1 | 1 selects the master role, 0 selects the slave role |
| eventOnly | input | 1 | Restrict snapshots to event messages |
| snapTake | output | 1 | Registered snapshot decision |

## Verification
Two things can fall in the same cycle here: a configuration change and a frame strobe. The bench provokes this in a random phase, where the enable, the mode, the role and the event-only bits are redrawn on every cycle, often in the very cycle of a strobe. Strobes also arrive back to back. Each decision is judged against a model evaluated with the inputs held in the strobe cycle, so a design that sampled the settings a cycle late or early would be caught.

// File: rtl/snap_filter_pkg.sv
package snap_filter_pkg;

  localparam int TYPE_W    = 4;
  localparam int NUM_TYPES = 1 << TYPE_W;

  localparam logic [TYPE_W-1:0] MSG_SYNC   = 4'h0;
  localparam logic [TYPE_W-1:0] MSG_DREQ   = 4'h1;
  localparam logic [TYPE_W-1:0] MSG_PREQ   = 4'h2;
  localparam logic [TYPE_W-1:0] MSG_PRESP  = 4'h3;
  localparam logic [TYPE_W-1:0] MSG_FOLLOW = 4'h8;
  localparam logic [TYPE_W-1:0] MSG_DRESP  = 4'h9;

  typedef enum logic [1:0] {
    MODE_ORD0 = 2'b00,
    MODE_ORD1 = 2'b01,
    MODE_E2E  = 2'b10,
    MODE_P2P  = 2'b11
  } modeSel_e;

  typedef struct packed {
    logic                 sampleEn;
    logic [NUM_TYPES-1:0] acceptMask;
  } snapCtrl_t;

endpackage

// File: rtl/snap_filter_ctrl.sv
module snap_filter_ctrl
  import snap_filter_pkg::*;
(
  input  logic      tsEnable,
  input  logic      frameValid,
  input  logic [1:0] modeSel,
  input  logic      masterSel,
  input  logic      eventOnly,
  output snapCtrl_t ctrlOut
);

  logic [NUM_TYPES-1:0] maskNext;

  always_comb begin
    maskNext = '0;
    unique case (modeSel_e'(modeSel))
      MODE_ORD0, MODE_ORD1: begin
        if (!eventOnly) begin
          maskNext[MSG_SYNC]   = 1'b1;
          maskNext[MSG_FOLLOW] = 1'b1;
          maskNext[MSG_DREQ]   = 1'b1;
          maskNext[MSG_DRESP]  = 1'b1;
        end else if (masterSel) begin
          maskNext[MSG_DREQ]   = 1'b1;
        end else begin
          maskNext[MSG_SYNC]   = 1'b1;
        end
      end
      MODE_E2E: begin
        maskNext[MSG_SYNC]   = 1'b1;
        maskNext[MSG_FOLLOW] = 1'b1;
        if (!eventOnly) begin
          maskNext[MSG_DREQ]  = 1'b1;
          maskNext[MSG_DRESP] = 1'b1;
        end
      end
      MODE_P2P: begin
        maskNext[MSG_SYNC]  = 1'b1;
        maskNext[MSG_PREQ]  = 1'b1;
        maskNext[MSG_PRESP] = 1'b1;
        if (!eventOnly) begin
          maskNext[MSG_FOLLOW] = 1'b1;
          maskNext[MSG_DREQ]   = 1'b1;
          maskNext[MSG_DRESP]  = 1'b1;
        end
      end
      default: maskNext = '0;
    endcase
  end

  always_comb begin
    ctrlOut.sampleEn   = frameValid & tsEnable;
    ctrlOut.acceptMask = maskNext;
  end

endmodule

// File: rtl/snap_filter_dp.sv
module snap_filter_dp
  import snap_filter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  snapCtrl_t         ctrlIn,
  input  logic [TYPE_W-1:0] msgType,
  output logic              snapTake
);

  logic [NUM_TYPES-1:0] typeHit;
  logic                 typeMatch;

  for (genvar gi = 0; gi < NUM_TYPES; gi++) begin : g_decode
    assign typeHit[gi] = (msgType == TYPE_W'(gi));
  end

  assign typeMatch = |(typeHit & ctrlIn.acceptMask);

  always_ff @(posedge clk) begin
    if (!rstN) snapTake <= 1'b0;
    else       snapTake <= ctrlIn.sampleEn & typeMatch;
  end

endmodule

// File: rtl/snap_filter_top.sv
module snap_filter_top
  import snap_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tsEnable,
  input  logic       frameValid,
  input  logic [3:0] msgType,
  input  logic [1:0] modeSel,
  input  logic       masterSel,
  input  logic       eventOnly,
  output logic       snapTake
);

  snapCtrl_t ctrlBus;

  snap_filter_ctrl ctrl_i (
    .tsEnable  (tsEnable),
    .frameValid(frameValid),
    .modeSel   (modeSel),
    .masterSel (masterSel),
    .eventOnly (eventOnly),
    .ctrlOut   (ctrlBus)
  );

  snap_filter_dp dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlIn  (ctrlBus),
    .msgType (msgType),
    .snapTake(snapTake)
  );

endmodule

// File: rtl/snap_filter_chk.sv
module snap_filter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tsEnable,
  input logic       frameValid,
  input logic [3:0] msgType,
  input logic [1:0] modeSel,
  input logic       masterSel,
  input logic       eventOnly,
  input logic       snapTake
);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tsEnable |=> !snapTake);

  // R10
  no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> !snapTake);

  // R9
  unknown_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && (msgType[2] || (msgType[3] && msgType[2:1] != 2'b00)))
      |=> !snapTake);

  // R3
  master_dreq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && tsEnable && !modeSel[1] && eventOnly && masterSel
     && msgType == 4'h1) |=> snapTake);

  // R7
  p2p_event_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && modeSel == 2'b11 && eventOnly && msgType == 4'h8)
      |=> !snapTake);

  // R6
  p2p_all_pdelay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && tsEnable && modeSel == 2'b11 && msgType == 4'h3)
      |=> snapTake);

endmodule

bind snap_filter_top snap_filter_chk chk_i (.*);

// File: tb/snap_filter_top_tb_top.sv
module snap_filter_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tsEnable;
  logic       frameValid;
  logic [3:0] msgType;
  logic [1:0] modeSel;
  logic       masterSel;
  logic       eventOnly;
  logic       snapTake;

  int checkCnt = 0;
  int failCnt  = 0;
  bit pendExp  = 1'b0;
  string pendTag = "R1";
  bit finished = 1'b0;

  always #10 clk = ~clk;

  snap_filter_top dut_i (.*);

  function automatic bit refSnap(bit v, bit en, logic [1:0] m, bit ms,
                                 bit eo, logic [3:0] t);
    bit sy, fu, dq, dr, pq, pr;
    if (!v || !en) return 1'b0;
    sy = (t == 4'h0); dq = (t == 4'h1); pq = (t == 4'h2);
    pr = (t == 4'h3); fu = (t == 4'h8); dr = (t == 4'h9);
    case (m)
      2'b00, 2'b01: return !eo ? (sy | fu | dq | dr) : (ms ? dq : sy);
      2'b10:        return eo ? (sy | fu) : (sy | fu | dq | dr);
      default:      return eo ? (sy | pq | pr) : (sy | fu | dq | dr | pq | pr);
    endcase
  endfunction

  function automatic string tagFor(bit v, bit en, logic [1:0] m, bit ms,
                                   bit eo, logic [3:0] t);
    if (!v) return "R10";
    if (!en) return "R8";
    if (t[2] || (t[3] && t[2:1] != 2'b00)) return "R9";
    if (m == 2'b10) return "R5";
    if (m == 2'b11) return eo ? "R7" : "R6";
    if (!eo) return "R2";
    return ms ? "R3" : "R4";
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: snapTake=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit en, logic [1:0] m, bit ms, bit eo,
                      logic [3:0] t, string tagOverride);
    @(negedge clk);
    check(snapTake, pendExp, pendTag);
    frameValid = v; tsEnable = en; modeSel = m;
    masterSel = ms; eventOnly = eo; msgType = t;
    pendExp = refSnap(v, en, m, ms, eo, t);
    pendTag = (tagOverride != "") ? tagOverride : tagFor(v, en, m, ms, eo, t);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      failCnt++; checkCnt++;
      $display("FAIL watchdog: actual=hang expected=completion");
      $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1588));
    rstN = 1'b0; tsEnable = 1'b1; frameValid = 1'b1; msgType = 4'h0;
    modeSel = 2'b00; masterSel = 1'b0; eventOnly = 1'b0;
    repeat (3) @(negedge clk);
    check(snapTake, 1'b0, "R1");
    frameValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    pendExp = 1'b0; pendTag = "R1";

    // directed sweep of every mode, role, event-only and type value
    for (int m = 0; m < 4; m++)
      for (int ms = 0; ms < 2; ms++)
        for (int eo = 0; eo < 2; eo++)
          for (int t = 0; t < 16; t++)
            step(1'b1, 1'b1, 2'(m), 1'(ms), 1'(eo), 4'(t), "");

    // R10: a single pulse after a strobe, then quiet
    step(1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 4'h0, "R10");
    step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 4'h0, "R10");
    step(1'b0, 1'b1, 2'b11, 1'b0, 1'b0, 4'h0, "R10");

    // R8: enable low on types that would otherwise be snapshotted
    for (int t = 0; t < 4; t++)
      step(1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 4'(t), "R8");

    // R11: a configuration change right after a strobe does not touch it
    step(1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 4'h1, "R11");
    step(1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 4'h1, "R11");
    step(1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 4'h1, "R11");
    step(1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 4'h1, "R11");

    // R11: random stimulus, settings redrawn every cycle
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] t;
      t = ($urandom % 3 == 0) ? 4'($urandom) :
          ((($urandom % 2) == 0) ? {1'b0, 1'b0, 2'($urandom)} :
                                   {3'b100, 1'($urandom)});
      step(($urandom % 4) != 0, ($urandom % 8) != 0, 2'($urandom),
           1'($urandom), 1'($urandom), t, "R11");
    end

    step(1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 4'h0, "R10");
    @(negedge clk);
    check(snapTake, pendExp, pendTag);
    finished = 1'b1;
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

endmodule